// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects up to 96 level-sensitive interrupt sources, arranged as three banks of 32, and presents two request lines to a processor: a normal request and a fast request. Each source's pending bit tracks its input level. A per-source mask removes a source from both request lines. A per-source select bit routes an unmasked pending source to the fast line as well.

The controller also computes a vector for the processor to read. The vector is the number of the lowest-numbered unmasked pending source, multiplied by four, so that it is word-aligned. A sticky fast-pending register records each source that has raised a fast request. Software clears it by writing ones. The remaining registers are a base-address word, a protect flag and an enable word per bank. The enable word is storage only and gates nothing.

Software reaches all registers over a simple 32-bit register bus. Each access carries a byte address with a read or a write strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `banked_vic`

## Requirements
- R1: Source n sets bit n mod 32 of pending bank n/32 one clock after its input is high, and clears that bit one clock after its input is low. Pending bank b reads at byte address 0x10 + 4*b.
- R2: `irq_o` is high exactly when some pending bit has its mask bit at 0. Mask bank b sits at 0x50 + 4*b, a 1 masks the source, and the reset value is 0.
- R3: `fiq_o` is high exactly when some source has its pending bit at 1, its select bit at 1 and its mask bit at 0. Select bank b sits at 0x30 + 4*b.
- R4: The vector register at 0x00 reads as 4 × the lowest source number that is pending and unmasked, and reads 0 when there is no such source. Writes to it are ignored.
- R5: The enable words at 0x40 + 4*b read back what was written, and they have no effect on `irq_o`, `fiq_o` or the vector.
- R6: Writes to the pending banks change neither the pending bits nor the outputs.
- R7: A fast-pending bit is set on a clock edge when its source is pending, selected and unmasked, and it then stays set. Fast-pending bank b sits at 0x20 + 4*b. Writing a 1 to a bit clears it, and a 0 leaves it unchanged. If the set condition still holds, the bit stays set.
- R8: The base-address register at 0x04 stores the written value with bits [1:0] forced to 0.
- R9: Within a register group, address bits [3:2] select the bank. The following read as 0 and ignore writes: bank slot 3, any offset outside the map, and any address with bits [1:0] non-zero.
- R10: While `rst_n` is low at a clock edge, every register clears to 0, so both outputs are low and the vector is 0.
- R11: `rd_data` loads the addressed register on the edge where `rd_en` is high, and it holds its value otherwise.
- R12: The protect register at 0x08 stores only bit 0 of the written value. Its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 96 | Level-sensitive interrupt sources |
| addr | input | 10 | Byte address of the register access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The priority search is tried with three source patterns:
- A single source in the middle bank shows the bank-to-offset arithmetic.
- Two sources in different banks show that the lower bank wins.
- Masking first the winner and then all remaining sources shows that the search skips masked bits and falls back to zero.

The fast path is tried with one selected source and one unselected source, which separates `fiq_o` from `irq_o`. A clearing write is issued both while the set condition still holds and after it has gone, which tells sticky set-wins behaviour apart from a plain write-one-to-clear. Writes are also aimed at the pending banks, an unused bank slot, a far offset and a misaligned address. Each of these is read back to show that nothing changed.

// File: rtl/vic_pkg.sv
// Package: shared constants and register-group codes for the banked
// vectored interrupt controller. Assumes 32-bit banks and byte addresses.
package vic_pkg;
    localparam int WORD_W = 32;

    // Register group: byte-address bits above [3:2]
    localparam logic [5:0] GRP_MISC  = 6'd0;  // vector, base, protect
    localparam logic [5:0] GRP_PEND  = 6'd1;
    localparam logic [5:0] GRP_FPEND = 6'd2;
    localparam logic [5:0] GRP_SEL   = 6'd3;
    localparam logic [5:0] GRP_EN    = 6'd4;
    localparam logic [5:0] GRP_MASK  = 6'd5;

    // Slots inside the miscellaneous group
    localparam logic [1:0] SLOT_VEC  = 2'd0;
    localparam logic [1:0] SLOT_BASE = 2'd1;
    localparam logic [1:0] SLOT_PROT = 2'd2;
endpackage

// File: rtl/vic_bank.sv
// Module: one bank of 32 sources. It holds the level-tracking pending
// bits, the sticky fast-pending bits, and the select, enable and mask
// words. Assumes the caller decodes the address into per-register
// write strobes.
module vic_bank
    import vic_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         wr_fpend,
    input  logic         wr_sel,
    input  logic         wr_en,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend,
    output logic [W-1:0] fpend,
    output logic [W-1:0] sel,
    output logic [W-1:0] en,
    output logic [W-1:0] mask,
    output logic [W-1:0] active,
    output logic [W-1:0] fast
);
    logic [W-1:0] clr_bits;

    // Purpose: unmasked pending bits, and their selected subset.
    always_comb begin
        active   = pend & ~mask;
        fast     = active & sel;
        clr_bits = wr_fpend ? wdata : '0;
    end

    // Purpose: sample the source levels and update all bank registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            fpend <= '0;
            sel   <= '0;
            en    <= '0;
            mask  <= '0;
        end else begin
            pend  <= src;
            fpend <= (fpend & ~clr_bits) | fast;
            if (wr_sel)  sel  <= wdata;
            if (wr_en)   en   <= wdata;
            if (wr_mask) mask <= wdata;
        end
    end
endmodule

// File: rtl/vic_prio.sv
// Module: lowest-source-first search across all banks. It returns
// 4 * source number of the first active bit, or zero when no bit is
// active. Assumes the active bits are packed with bank 0 in the LSBs.
module vic_prio
    import vic_pkg::*;
#(
    parameter int NB = 3,
    parameter int W  = WORD_W
) (
    input  logic [NB*W-1:0]   active,
    output logic [WORD_W-1:0] vector
);
    localparam int N = NB * W;

    logic found;

    // Purpose: scan from source 0 upward and keep the first hit.
    always_comb begin
        found  = 1'b0;
        vector = '0;
        for (int n = 0; n < N; n++) begin
            if (!found && active[n]) begin
                found  = 1'b1;
                vector = WORD_W'(n * 4);
            end
        end
    end
endmodule

// File: rtl/banked_vic.sv
// Module: top level of the banked vectored interrupt controller. It
// decodes the register bus, instantiates one bank per 32 sources, ORs
// the request lines and registers the read data. Assumes at most three
// banks, since address bits [3:2] pick the bank and slot 3 is unused.
module banked_vic
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*WORD_W-1:0] irq_src,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       rd_en,
    input  logic                       wr_en,
    input  logic [WORD_W-1:0]          wr_data,
    output logic [WORD_W-1:0]          rd_data,
    output logic                       irq_o,
    output logic                       fiq_o
);
    localparam int NUM_SRC = NUM_BANKS * WORD_W;
    localparam int GRP_W   = ADDR_W - 4;

    logic [GRP_W-1:0]  grp;
    logic [1:0]        slot;
    logic              aligned;
    logic [WORD_W-1:0] pend_b  [NUM_BANKS];
    logic [WORD_W-1:0] fpend_b [NUM_BANKS];
    logic [WORD_W-1:0] sel_b   [NUM_BANKS];
    logic [WORD_W-1:0] en_b    [NUM_BANKS];
    logic [WORD_W-1:0] mask_b  [NUM_BANKS];
    logic [NUM_SRC-1:0] pend_flat, fpend_flat, sel_flat, mask_flat;
    logic [NUM_SRC-1:0] active_flat, fast_flat;
    logic [WORD_W-1:0] vector, base_q, rd_next;
    logic              prot_q;

    // Purpose: split the byte address into group, bank slot and alignment.
    always_comb begin
        grp     = addr[ADDR_W-1:4];
        slot    = addr[3:2];
        aligned = (addr[1:0] == 2'b00);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_en && aligned && (slot == 2'(b));

        vic_bank #(.W(WORD_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (irq_src[b*WORD_W +: WORD_W]),
            .wr_fpend (hit && (grp == GRP_W'(GRP_FPEND))),
            .wr_sel   (hit && (grp == GRP_W'(GRP_SEL))),
            .wr_en    (hit && (grp == GRP_W'(GRP_EN))),
            .wr_mask  (hit && (grp == GRP_W'(GRP_MASK))),
            .wdata    (wr_data),
            .pend     (pend_b[b]),
            .fpend    (fpend_b[b]),
            .sel      (sel_b[b]),
            .en       (en_b[b]),
            .mask     (mask_b[b]),
            .active   (active_flat[b*WORD_W +: WORD_W]),
            .fast     (fast_flat[b*WORD_W +: WORD_W])
        );

        assign pend_flat[b*WORD_W +: WORD_W]  = pend_b[b];
        assign fpend_flat[b*WORD_W +: WORD_W] = fpend_b[b];
        assign sel_flat[b*WORD_W +: WORD_W]   = sel_b[b];
        assign mask_flat[b*WORD_W +: WORD_W]  = mask_b[b];
    end

    vic_prio #(.NB(NUM_BANKS), .W(WORD_W)) u_prio (
        .active (active_flat),
        .vector (vector)
    );

    // Purpose: drive the processor request lines.
    always_comb begin
        irq_o = |active_flat;
        fiq_o = |fast_flat;
    end

    // Purpose: base-address and protect registers in the miscellaneous group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            prot_q <= 1'b0;
        end else if (wr_en && aligned && grp == GRP_W'(GRP_MISC)) begin
            if (slot == SLOT_BASE) base_q <= {wr_data[WORD_W-1:2], 2'b00};
            if (slot == SLOT_PROT) prot_q <= wr_data[0];
        end
    end

    // Purpose: select the addressed register for a read; unmapped reads give 0.
    always_comb begin
        rd_next = '0;
        if (aligned) begin
            if (grp == GRP_W'(GRP_MISC)) begin
                case (slot)
                    SLOT_VEC:  rd_next = vector;
                    SLOT_BASE: rd_next = base_q;
                    SLOT_PROT: rd_next = {{(WORD_W-1){1'b0}}, prot_q};
                    default:   rd_next = '0;
                endcase
            end else begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (slot == 2'(b)) begin
                        case (grp)
                            GRP_W'(GRP_PEND):  rd_next = pend_b[b];
                            GRP_W'(GRP_FPEND): rd_next = fpend_b[b];
                            GRP_W'(GRP_SEL):   rd_next = sel_b[b];
                            GRP_W'(GRP_EN):    rd_next = en_b[b];
                            GRP_W'(GRP_MASK):  rd_next = mask_b[b];
                            default:           rd_next = '0;
                        endcase
                    end
                end
            end
        end
    end

    // Purpose: register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/vic_chk.sv
// Module: property checker for banked_vic, attached by bind. It watches
// the source inputs, the flattened bank state and the request outputs.
module vic_chk #(
    parameter int NUM_SRC = 96
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_src,
    input logic [NUM_SRC-1:0] pend_flat,
    input logic [NUM_SRC-1:0] fpend_flat,
    input logic [NUM_SRC-1:0] sel_flat,
    input logic [NUM_SRC-1:0] mask_flat,
    input logic [31:0]        base_q,
    input logic [31:0]        vector,
    input logic               irq_o,
    input logic               fiq_o
);
    logic [NUM_SRC-1:0] set_cond;
    assign set_cond = sel_flat & pend_flat & ~mask_flat;

    // R1
    pend_tracks_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_flat == $past(irq_src)));

    // R2
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_flat & ~mask_flat) == '0) |-> !irq_o);

    // R3
    fiq_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    // R4
    vector_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vector[1:0] == 2'b00) && (vector < 32'(NUM_SRC * 4)));

    // R7
    fpend_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fpend_flat & ~$past(fpend_flat) & ~$past(set_cond)) == '0));

    // R8
    base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[1:0] == 2'b00);
endmodule

bind banked_vic vic_chk #(.NUM_SRC(NUM_SRC)) u_vic_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_src    (irq_src),
    .pend_flat  (pend_flat),
    .fpend_flat (fpend_flat),
    .sel_flat   (sel_flat),
    .mask_flat  (mask_flat),
    .base_q     (base_q),
    .vector     (vector),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o)
);

// File: tb/test_banked_vic.sv
// Bench: directed scenarios for banked_vic, one task each, driven on
// the falling edge and sampled on the falling edge.
module test_banked_vic;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] irq_src = '0;
    logic [9:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o, fiq_o;
    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] r;

    always #4 clk = ~clk;  // 125 MHz

    banked_vic i_banked_vic (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    // Drive sources and wait so pending and fast-pending have settled.
    task automatic drive(input logic [95:0] v);
        @(negedge clk); irq_src = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 irq after reset", 32'(irq_o), 32'd0);
        chk("R10 fiq after reset", 32'(fiq_o), 32'd0);
        bus_rd(10'h000, r); chk("R10 vector after reset", r, 32'd0);
        bus_rd(10'h054, r); chk("R10 mask bank1 after reset", r, 32'd0);
    endtask

    task automatic t_level();
        logic [95:0] v = '0;
        v[37] = 1'b1;
        drive(v);
        bus_rd(10'h014, r); chk("R1 pend bank1 bit5", r, 32'h20);
        chk("R2 irq with one source", 32'(irq_o), 32'd1);
        chk("R3 fiq unselected", 32'(fiq_o), 32'd0);
        bus_rd(10'h000, r); chk("R4 vector src37", r, 32'd148);
        bus_rd(10'h010, r); chk("R11 read bank0 empty", r, 32'd0);
        drive('0);
        bus_rd(10'h014, r); chk("R1 pend cleared on low", r, 32'd0);
        chk("R2 irq low", 32'(irq_o), 32'd0);
    endtask

    task automatic t_priority();
        logic [95:0] v = '0;
        v[70] = 1'b1; v[40] = 1'b1;
        drive(v);
        bus_rd(10'h000, r); chk("R4 lower bank wins", r, 32'd160);
        bus_wr(10'h054, 32'h100);
        bus_rd(10'h000, r); chk("R4 masked winner skipped", r, 32'd280);
        bus_wr(10'h058, 32'h40);
        @(negedge clk);
        chk("R2 all masked irq low", 32'(irq_o), 32'd0);
        bus_rd(10'h000, r); chk("R4 none active vector zero", r, 32'd0);
        bus_wr(10'h054, 32'h0); bus_wr(10'h058, 32'h0);
        drive('0);
    endtask

    task automatic t_fast();
        logic [95:0] v = '0;
        v[3] = 1'b1; v[1] = 1'b1;
        bus_wr(10'h030, 32'h8);
        drive(v);
        chk("R3 fiq selected", 32'(fiq_o), 32'd1);
        bus_rd(10'h000, r); chk("R4 vector src1", r, 32'd4);
        bus_rd(10'h020, r); chk("R7 fast pending set", r, 32'h8);
        bus_wr(10'h020, 32'h8);
        bus_rd(10'h020, r); chk("R7 set wins over clear", r, 32'h8);
        drive('0);
        chk("R3 fiq low after drop", 32'(fiq_o), 32'd0);
        bus_rd(10'h020, r); chk("R7 sticky after drop", r, 32'h8);
        bus_wr(10'h020, 32'h4);
        bus_rd(10'h020, r); chk("R7 zero bits keep", r, 32'h8);
        bus_wr(10'h020, 32'h8);
        bus_rd(10'h020, r); chk("R7 write one clears", r, 32'h0);
        bus_wr(10'h030, 32'h0);
    endtask

    task automatic t_enable();
        logic [95:0] v = '0;
        v[90] = 1'b1;
        bus_wr(10'h048, 32'h0);
        bus_wr(10'h040, 32'hA5A5_0F0F);
        drive(v);
        chk("R5 enable does not gate irq", 32'(irq_o), 32'd1);
        bus_rd(10'h040, r); chk("R5 enable readback", r, 32'hA5A5_0F0F);
        bus_rd(10'h000, r); chk("R5 vector ungated", r, 32'd360);
        drive('0);
    endtask

    task automatic t_pend_write();
        bus_wr(10'h010, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R6 irq after pend write", 32'(irq_o), 32'd0);
        bus_rd(10'h010, r); chk("R6 pend unchanged", r, 32'd0);
    endtask

    task automatic t_misc();
        bus_wr(10'h004, 32'h0000_1237);
        bus_rd(10'h004, r); chk("R8 base low bits zero", r, 32'h1234);
        bus_wr(10'h008, 32'hFF);
        bus_rd(10'h008, r); chk("R12 protect bit0 only", r, 32'h1);
        bus_wr(10'h000, 32'hFFFF_FFF0);
        bus_rd(10'h000, r); chk("R4 vector write ignored", r, 32'd0);
    endtask

    task automatic t_unmapped();
        bus_wr(10'h03C, 32'hFFFF_FFFF);
        bus_rd(10'h03C, r); chk("R9 slot3 reads zero", r, 32'd0);
        bus_rd(10'h030, r); chk("R9 slot3 write ignored", r, 32'd0);
        bus_wr(10'h200, 32'h1234_5678);
        bus_rd(10'h200, r); chk("R9 far offset zero", r, 32'd0);
        bus_wr(10'h052, 32'hFFFF_FFFF);
        bus_rd(10'h050, r); chk("R9 misaligned write ignored", r, 32'd0);
        bus_rd(10'h042, r); chk("R9 misaligned read zero", r, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_priority();
        t_fast();
        t_enable();
        t_pend_write();
        t_misc();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule